// File: doc/BRIEF.md
# Match-Channel Timer with Watchdog Reset

This block is a memory-mapped timer. A 64-bit tick counter advances once for every cycle in which the tick-enable input is high. At the nominal 1 MHz tick rate, one second is 1,000,000 counts.

Six 32-bit compare channels watch the low word of the counter. Each channel keeps a sticky hit flag, and a per-channel enable mask turns the flags into interrupt lines. Software reads a coherent counter value in two steps: it writes a command register, which snapshots the counter, and then reads the held copy.

Compare channel 5 also acts as the watchdog. When its compare value is reached, and both its interrupt-enable bit and a separate arm register are set, the block raises a system reset request for a fixed number of clocks. Software keeps the system alive by rewriting channel 5's compare value further ahead (a ping). Clearing either enable stops a request at once.

Register offsets on the 8-bit byte address: counter low 0x00, counter high 0x04, compare channel n at 0x08 + 4·n (channel 5 at 0x1C), interrupt mask 0x24, watchdog arm 0x28, snapshot command 0x30, snapshot value 0x34.

Top module: `tick_match_wdog`

## Requirements
- R1: After reset the counter, all compare registers, the interrupt mask, the arm register, the snapshot value and every hit flag are zero, so all irq bits and sys_rst_req are low.
- R2: The counter increases by one at each clock edge where tick_en is high, and holds otherwise. The low word carries into the high word. A write to 0x00 loads the low word and a write to 0x04 loads the high word; a load takes priority over a tick in the same cycle.
- R3: The compare register of channel n (offset 0x08 + 4·n) reads back exactly as written. The interrupt mask at 0x24 reads back bits 5:0 as written, with bit n belonging to channel n, and reads zero above them. The arm register at 0x28 keeps only bit 0.
- R4: At a clock edge with tick_en high and counter bits 31:0 equal to channel n's compare value, the hit flag of channel n is set and stays set. irq[n] is high while that flag is set and mask bit n is 1. An equal counter with tick_en low sets nothing.
- R5: Writing channel n's compare register clears that channel's hit flag, so irq[n] stays low until the next hit.
- R6: A write to 0x30 with bit 0 = 1 copies counter bits 31:0, as they stood before that edge, into the value read at 0x34. That value then holds while the counter runs. A write with bit 0 = 0 does not copy. Offset 0x30 reads as zero.
- R7: A channel 5 hit at an edge where mask bit 5 and arm bit 0 are both 1 drives sys_rst_req high for exactly 16 clocks, starting right after that edge. Each hit starts the request once.
- R8: A channel 5 hit while mask bit 5 or arm bit 0 is 0 produces no reset request. Setting the enables later does not produce one for that earlier hit.
- R9: Writing 0 to arm bit 0, or clearing mask bit 5, makes sys_rst_req low from the edge of that write onward. Re-arming does not resume the cut-off request.
- R10: The compare uses the counter's low word modulo 2^32. A compare value below the current low word is reached after the low word wraps through zero.
- R11: Reads of any offset not listed return zero. Writes to them change no register.
- R12: Hits on channels 0 to 4 raise only their own irq bits and never a reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the counter at this edge |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 6 | Per-channel interrupt, hit flag AND mask bit |
| sys_rst_req | output | 1 | Watchdog system reset request |

## Verification
The bench sets up a 32-bit wrap and places a compare value just past zero. A magnitude compare instead of an equality compare would fire at once, or never fire. It cuts an active reset request by clearing the arm bit and then re-arms. A stretcher that gated only its output, without clearing its count, would resume the request. It counts the exact number of request cycles: a stretcher that is off by one gives 15 or 17. It also hits channel 5 with an enable missing and then sets the enable. A design that triggered on the sticky flag instead of on the hit event would then issue a late reset. Finally, it checks that a held snapshot ignores a running counter and a command with bit 0 clear.

// File: rtl/tmw_pkg.sv
package tmw_pkg;
    localparam int unsigned NUM_CH_DEF   = 6;
    localparam int unsigned WD_CH_DEF    = 5;
    localparam int unsigned DATA_W       = 32;
    localparam int unsigned CNT_W_DEF    = 64;
    localparam int unsigned ADDR_W       = 8;
    localparam int unsigned RST_LEN_DEF  = 16;

    localparam logic [ADDR_W-1:0] OFS_CNT_LO   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CMP_BASE = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK     = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_ARM      = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_SNAP_CMD = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_SNAP_VAL = 8'h34;
endpackage

// File: rtl/tmw_counter.sv
module tmw_counter #(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic             snap,
    input  logic [DW-1:0]    wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [DW-1:0]    snap_val
);
    localparam int unsigned HW = CNT_W - DW;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    snap;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_lo)      st_d.cnt = {st_q.cnt[CNT_W-1:DW], wdata};
        else if (ld_hi) st_d.cnt = {wdata[HW-1:0], st_q.cnt[DW-1:0]};
        else if (tick)  st_d.cnt = st_q.cnt + CNT_W'(1);
        if (snap)       st_d.snap = st_q.cnt[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign snap_val = st_q.snap;
endmodule

// File: rtl/tmw_match_bank.sv
module tmw_match_bank #(
    parameter int unsigned NCH = 6,
    parameter int unsigned DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DW-1:0]     cnt_lo,
    input  logic [NCH-1:0]    wr_cmp,
    input  logic              wr_mask,
    input  logic [DW-1:0]     wdata,
    output logic [NCH*DW-1:0] cmp_flat,
    output logic [NCH-1:0]    mask,
    output logic [NCH-1:0]    flag,
    output logic [NCH-1:0]    hit
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] cmp;
        logic [NCH-1:0]         mask;
        logic [NCH-1:0]         flag;
    } bank_st_t;

    bank_st_t st_d, st_q;

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign hit[g] = tick && (cnt_lo == st_q.cmp[g]);
        assign cmp_flat[g*DW +: DW] = st_q.cmp[g];
    end

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NCH; n++) begin
            if (wr_cmp[n]) st_d.cmp[n] = wdata;
        end
        if (wr_mask) st_d.mask = wdata[NCH-1:0];
        // a hit in the same cycle as a rewrite wins, so no event is lost
        st_d.flag = (st_q.flag & ~wr_cmp) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask = st_q.mask;
    assign flag = st_q.flag;
endmodule

// File: rtl/tmw_wdog.sv
module tmw_wdog #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_arm,
    input  logic arm_bit,
    input  logic wd_hit,
    input  logic wd_mask,
    output logic armed,
    output logic arm_reg,
    output logic rst_req
);
    localparam int unsigned LW = $clog2(LEN + 1);

    typedef struct packed {
        logic          arm;
        logic [LW-1:0] left;
    } wd_st_t;

    wd_st_t st_d, st_q;

    assign armed = st_q.arm && wd_mask;

    always_comb begin
        st_d = st_q;
        if (wr_arm) st_d.arm = arm_bit;
        if (!armed)                st_d.left = '0;
        else if (wd_hit)           st_d.left = LW'(LEN);
        else if (st_q.left != '0)  st_d.left = st_q.left - LW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign arm_reg = st_q.arm;
    assign rst_req = (st_q.left != '0) && armed;
endmodule

// File: rtl/tick_match_wdog.sv
module tick_match_wdog #(
    parameter int unsigned NUM_CH  = tmw_pkg::NUM_CH_DEF,
    parameter int unsigned WD_CH   = tmw_pkg::WD_CH_DEF,
    parameter int unsigned CNT_W   = tmw_pkg::CNT_W_DEF,
    parameter int unsigned RST_LEN = tmw_pkg::RST_LEN_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_en,
    input  logic                        bus_wr,
    input  logic [tmw_pkg::ADDR_W-1:0]  bus_addr,
    input  logic [tmw_pkg::DATA_W-1:0]  bus_wdata,
    output logic [tmw_pkg::DATA_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0]           irq,
    output logic                        sys_rst_req
);
    import tmw_pkg::*;
    localparam int unsigned DW = DATA_W;
    localparam int unsigned AW = ADDR_W;

    logic [CNT_W-1:0]     cnt_q;
    logic [DW-1:0]        snap_q;
    logic [NUM_CH*DW-1:0] cmp_flat;
    logic [NUM_CH-1:0]    mask, flag, hit, wr_cmp;
    logic                 ld_lo, ld_hi, ld_any, snap_wr, wr_mask, wr_arm;
    logic                 armed, arm_reg;

    assign ld_lo   = bus_wr && (bus_addr == OFS_CNT_LO);
    assign ld_hi   = bus_wr && (bus_addr == OFS_CNT_HI);
    assign ld_any  = ld_lo || ld_hi;
    assign snap_wr = bus_wr && (bus_addr == OFS_SNAP_CMD) && bus_wdata[0];
    assign wr_mask = bus_wr && (bus_addr == OFS_MASK);
    assign wr_arm  = bus_wr && (bus_addr == OFS_ARM);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign wr_cmp[g] = bus_wr && (bus_addr == AW'(OFS_CMP_BASE + 4 * g));
    end

    tmw_counter #(.CNT_W(CNT_W), .DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .snap(snap_wr), .wdata(bus_wdata), .cnt(cnt_q), .snap_val(snap_q)
    );

    tmw_match_bank #(.NCH(NUM_CH), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .cnt_lo(cnt_q[DW-1:0]),
        .wr_cmp(wr_cmp), .wr_mask(wr_mask), .wdata(bus_wdata),
        .cmp_flat(cmp_flat), .mask(mask), .flag(flag), .hit(hit)
    );

    tmw_wdog #(.LEN(RST_LEN)) u_wd (
        .clk(clk), .rst_n(rst_n), .wr_arm(wr_arm), .arm_bit(bus_wdata[0]),
        .wd_hit(hit[WD_CH]), .wd_mask(mask[WD_CH]), .armed(armed),
        .arm_reg(arm_reg), .rst_req(sys_rst_req)
    );

    assign irq = flag & mask;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CNT_LO)        bus_rdata = cnt_q[DW-1:0];
        else if (bus_addr == OFS_CNT_HI)   bus_rdata = DW'(cnt_q[CNT_W-1:DW]);
        else if (bus_addr == OFS_MASK)     bus_rdata = DW'(mask);
        else if (bus_addr == OFS_ARM)      bus_rdata = DW'(arm_reg);
        else if (bus_addr == OFS_SNAP_VAL) bus_rdata = snap_q;
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == AW'(OFS_CMP_BASE + 4 * n)) bus_rdata = cmp_flat[n*DW +: DW];
        end
    end
endmodule

// File: rtl/tmw_sva.sv
module tmw_sva #(
    parameter int unsigned NUM_CH  = 6,
    parameter int unsigned WD_CH   = 5,
    parameter int unsigned CNT_W   = 64,
    parameter int unsigned DW      = 32,
    parameter int unsigned RST_LEN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              ld_any,
    input logic              snap_wr,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [DW-1:0]     snap_q,
    input logic [NUM_CH-1:0] flag,
    input logic [NUM_CH-1:0] wr_cmp,
    input logic [NUM_CH-1:0] hit,
    input logic              armed,
    input logic              sys_rst_req
);
    localparam int unsigned RW = $clog2(RST_LEN + 2);
    logic          live_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            run_q  <= '0;
        end else begin
            live_q <= 1'b1;
            if (!sys_rst_req)         run_q <= '0;
            else if (run_q <= RW'(RST_LEN)) run_q <= run_q + RW'(1);
        end
    end

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(ld_any) && $past(tick_en)) |-> cnt_q == $past(cnt_q) + CNT_W'(1));

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(ld_any) && !$past(tick_en)) |-> cnt_q == $past(cnt_q));

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (($past(flag) & ~$past(wr_cmp)) & ~flag) == '0);

    p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(snap_wr)) |-> snap_q == $past(snap_q));

    p_rst_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $rose(sys_rst_req)) |-> $past(hit[WD_CH] && armed));

    p_rst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(RST_LEN));

    p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $fell(armed)) |-> !sys_rst_req);
endmodule

bind tick_match_wdog tmw_sva #(
    .NUM_CH(NUM_CH), .WD_CH(WD_CH), .CNT_W(CNT_W), .DW(DW), .RST_LEN(RST_LEN)
) u_sva (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ld_any(ld_any), .snap_wr(snap_wr),
    .cnt_q(cnt_q), .snap_q(snap_q), .flag(flag), .wr_cmp(wr_cmp), .hit(hit),
    .armed(armed), .sys_rst_req(sys_rst_req)
);

// File: tb/sim_tick_match_wdog.sv
module sim_tick_match_wdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  irq;
    logic        sys_rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tick_match_wdog u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic set_cnt(logic [31:0] hi, logic [31:0] lo);
        wr(8'h04, hi);
        wr(8'h00, lo);
    endtask

    task automatic count_rst(int cycles, output int highs);
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            if (sys_rst_req) highs++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); chk("R1 counter low", v, 0);
        rd(8'h24, v); chk("R1 mask", v, 0);
        rd(8'h1C, v); chk("R1 compare5", v, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rst_req", 32'(sys_rst_req), 0);
    endtask

    task automatic t_counter;
        logic [31:0] v;
        set_cnt(32'h7, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R2 load low", v, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R2 load high", v, 32'h7);
        ticks(1);
        rd(8'h00, v); chk("R2 carry low", v, 0);
        rd(8'h04, v); chk("R2 carry high", v, 32'h8);
        repeat (5) @(negedge clk);
        rd(8'h00, v); chk("R2 hold", v, 0);
        ticks(10);
        rd(8'h00, v); chk("R2 count ten", v, 10);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(8'h24, 0);
        for (int n = 0; n < 6; n++) wr(8'(8 + 4 * n), 32'hA500_0000 | 32'(n * 257));
        for (int n = 0; n < 6; n++) begin
            rd(8'(8 + 4 * n), v);
            chk("R3 compare readback", v, 32'hA500_0000 | 32'(n * 257));
        end
        wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, v); chk("R3 mask upper zero", v, 32'h3F);
        wr(8'h24, 32'h15);        rd(8'h24, v); chk("R3 mask readback", v, 32'h15);
        wr(8'h28, 32'h3);         rd(8'h28, v); chk("R3 arm bit0 only", v, 1);
        wr(8'h28, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(8'h2C, 32'hDEAD_BEEF);
        wr(8'h20, 32'h1234_5678);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h2C, v); chk("R11 read 2C", v, 0);
        rd(8'h20, v); chk("R11 read 20", v, 0);
        rd(8'h3C, v); chk("R11 read 3C", v, 0);
        rd(8'h30, v); chk("R6 cmd reads zero", v, 0);
        rd(8'h24, v); chk("R11 mask untouched", v, 32'h15);
        rd(8'h28, v); chk("R11 arm untouched", v, 0);
        rd(8'h1C, v); chk("R11 compare5 untouched", v, 32'hA500_0505);
    endtask

    task automatic t_snapshot;
        logic [31:0] v;
        set_cnt(0, 32'h1234);
        wr(8'h30, 1);
        rd(8'h34, v); chk("R6 snapshot taken", v, 32'h1234);
        ticks(20);
        rd(8'h34, v); chk("R6 snapshot holds", v, 32'h1234);
        rd(8'h00, v); chk("R6 live counter moved", v, 32'h1234 + 20);
        set_cnt(0, 32'h999);
        wr(8'h30, 32'h2);
        rd(8'h34, v); chk("R6 bit0 clear no copy", v, 32'h1234);
        wr(8'h30, 1);
        rd(8'h34, v); chk("R6 second snapshot", v, 32'h999);
    endtask

    task automatic t_match;
        wr(8'h24, 32'h04);
        for (int n = 0; n < 6; n++) wr(8'(8 + 4 * n), 32'hF000_0000);
        wr(8'h10, 105);
        set_cnt(0, 100);
        ticks(5);
        chk("R4 no hit before", 32'(irq), 0);
        ticks(1);
        chk("R4 hit ch2", 32'(irq), 32'h04);
        repeat (10) @(negedge clk);
        chk("R4 flag sticky", 32'(irq), 32'h04);
        wr(8'h24, 0);
        chk("R4 mask gates irq", 32'(irq), 0);
        wr(8'h10, 500);
        wr(8'h24, 32'h04);
        chk("R5 rewrite clears flag", 32'(irq), 0);
        wr(8'h24, 32'h08);
        wr(8'h14, 50);
        set_cnt(0, 50);
        repeat (5) @(negedge clk);
        chk("R4 equal without tick", 32'(irq), 0);
        ticks(1);
        chk("R4 equal with tick", 32'(irq), 32'h08);
        wr(8'h14, 32'hF000_0000);
    endtask

    task automatic t_wdog_fire;
        int h;
        wr(8'h24, 32'h20);
        wr(8'h28, 1);
        wr(8'h1C, 203);
        set_cnt(0, 200);
        ticks(3);
        chk("R7 no request before hit", 32'(sys_rst_req), 0);
        ticks(1);
        chk("R7 irq5 on hit", 32'(irq), 32'h20);
        count_rst(24, h);
        chk("R7 request length", 32'(h), 16);
    endtask

    task automatic t_wdog_gated;
        int h;
        wr(8'h24, 0);
        wr(8'h28, 1);
        wr(8'h1C, 302);
        set_cnt(0, 300);
        ticks(3);
        count_rst(20, h);
        chk("R8 mask off no request", 32'(h), 0);
        wr(8'h24, 32'h20);
        chk("R8 flag seen late", 32'(irq), 32'h20);
        count_rst(20, h);
        chk("R8 late enable no request", 32'(h), 0);
        wr(8'h28, 0);
        wr(8'h1C, 402);
        set_cnt(0, 400);
        ticks(3);
        chk("R8 arm off irq5", 32'(irq), 32'h20);
        count_rst(20, h);
        chk("R8 arm off no request", 32'(h), 0);
    endtask

    task automatic t_disarm;
        int h;
        wr(8'h24, 32'h20);
        wr(8'h28, 1);
        wr(8'h1C, 502);
        set_cnt(0, 500);
        ticks(3);
        chk("R9 request active", 32'(sys_rst_req), 1);
        wr(8'h28, 0);
        chk("R9 disarm drops request", 32'(sys_rst_req), 0);
        wr(8'h28, 1);
        count_rst(20, h);
        chk("R9 rearm no resume", 32'(h), 0);
        wr(8'h1C, 602);
        set_cnt(0, 600);
        ticks(3);
        chk("R9 request active again", 32'(sys_rst_req), 1);
        wr(8'h24, 0);
        chk("R9 mask clear drops request", 32'(sys_rst_req), 0);
        wr(8'h28, 0);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(8'h1C, 32'hF000_0000);
        wr(8'h24, 32'h01);
        wr(8'h08, 1);
        set_cnt(0, 32'hFFFF_FFFE);
        ticks(3);
        chk("R10 not before wrap", 32'(irq), 0);
        ticks(1);
        chk("R10 hit after wrap", 32'(irq), 32'h01);
        rd(8'h04, v); chk("R10 high word carried", v, 1);
        wr(8'h08, 32'hF000_0000);
    endtask

    task automatic t_others;
        int h;
        wr(8'h28, 1);
        wr(8'h1C, 32'hFFFF_0000);
        for (int n = 0; n < 5; n++) wr(8'(8 + 4 * n), 702);
        wr(8'h24, 32'h3F);
        set_cnt(0, 700);
        ticks(3);
        chk("R12 channels 0-4 irq", 32'(irq), 32'h1F);
        count_rst(20, h);
        chk("R12 no request from others", 32'(h), 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counter();
        t_regs();
        t_unmapped();
        t_snapshot();
        t_match();
        t_wdog_fire();
        t_wdog_gated();
        t_disarm();
        t_wrap();
        t_others();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule